// File: doc/BRIEF.md
# Memory-Mapped Serial Host Slave

This block lets an external host reach a 22-bit byte address space over a four-wire serial link in clock mode 0 (data sampled on the rising edge of the serial clock and changed on the falling edge, most significant bit first). The first byte of each transaction carries a 2-bit operation prefix. A read or a write carries a 22-bit start address. A read inserts one dummy byte before data comes back, and a burst of any length runs at incrementing addresses. A third prefix frames a short 3-byte host command, which the block decodes into a single-cycle pulse toward the power and clock controller.

All pin signals are brought into the system clock domain through synchronizer flops, and the edges of the serial clock are detected there. The internal side is a simple synchronous bus with one cycle of read latency: address, write data, a write strobe, a read request and read data. While the core sits in a low-power state, a read of address 0 is reported as a wake request on the command outputs. The serial clock half period must be at least four system clock cycles.

Top module: `spi_host_slave`

## Requirements
- R1: While chip select has been high for 4 or more clocks, `spi_miso_oe` and `spi_miso` are 0 and no bus or command strobe fires; a reset leaves the block in this state.
- R2: First byte with bits [7:6] = 10 and bits [5:0] = address[21:16], then address[15:8] and address[7:0]: every later byte produces one `bus_we` pulse carrying that byte, at the start address for the first byte and one higher for each byte after it.
- R3: First byte with bits [7:6] = 00 and the same address layout, then one dummy byte: every host byte after the dummy shifts out, MSB first, the byte stored at the start address plus its index in the burst.
- R4: A read issues `bus_re` once when the last address byte completes and once at the end of the dummy byte and of every data byte, each at the next address; `bus_re` and `bus_we` never fire together.
- R5: The burst address wraps from 3FFFFFh to 000000h.
- R6: First byte with bits [7:6] = 01 carries a 6-bit code in bits [5:0]; if the next two bytes are both 00h and the code is one of 00h, 01h, 02h, 04h, 08h, 10h, 21h, 22h or 28h, `cmd_valid` pulses for one clock with `cmd_code` equal to the code.
- R7: A command whose code is not in that list, or whose second or third byte is nonzero, produces no pulse.
- R8: A first byte with bits [7:6] = 11 produces no bus access and no command for the rest of the transaction, and MISO stays 0.
- R9: A read of address 0 while `low_power` is 1 produces one `cmd_valid` pulse with code 00h (wake). A read of address 0 with `low_power` at 0, or of any other address, produces no pulse.
- R10: Raising chip select in the middle of a byte discards the partial byte, and the next transaction decodes from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Serial data to the host, 0 when not selected |
| spi_miso_oe | output | 1 | Output enable for the MISO pad |
| low_power | input | 1 | Core is in standby or sleep |
| bus_addr | output | 22 | Byte address of the current access |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | Write strobe, one clock per byte |
| bus_re | output | 1 | Read request, one clock per byte |
| bus_rdata | input | 8 | Read data, valid one clock after `bus_re` |
| cmd_valid | output | 1 | Single-clock command pulse |
| cmd_code | output | 6 | Code of the command being pulsed |

## Verification
The bench reads back write bursts, including a burst that crosses the top of the address space. A design that did not wrap would store bytes at the wrong location, and one that prefetched late would shift out stale or off-by-one data. It checks the wake rule against all three of its conditions, since a loose address or state compare would wake the core on ordinary reads. It sends commands with reserved codes and with nonzero trailing bytes, which a decoder that looked only at the first byte would let through. It also aborts a byte halfway, and a design that failed to clear its bit counter on deselect would misframe every later transaction.

// File: rtl/spi_host_pkg.sv
// Shared types and constants for the serial host slave.
// Assumes an 8-bit byte and a 2-bit operation prefix in the first byte.
package spi_host_pkg;

    // Operation prefix in bits [7:6] of the first byte.
    localparam logic [1:0] PFX_READ  = 2'b00;
    localparam logic [1:0] PFX_CMD   = 2'b01;
    localparam logic [1:0] PFX_WRITE = 2'b10;
    localparam logic [1:0] PFX_UNDEF = 2'b11;

    // Command codes carried in bits [5:0] of a command byte.
    localparam logic [5:0] CMD_WAKE     = 6'h00;
    localparam logic [5:0] CMD_STANDBY  = 6'h01;
    localparam logic [5:0] CMD_NAP      = 6'h02;
    localparam logic [5:0] CMD_SRC_XTAL = 6'h04;
    localparam logic [5:0] CMD_SRC_RC   = 6'h08;
    localparam logic [5:0] CMD_OFF      = 6'h10;
    localparam logic [5:0] CMD_PLL_LOW  = 6'h21;
    localparam logic [5:0] CMD_PLL_HIGH = 6'h22;
    localparam logic [5:0] CMD_CORE_RST = 6'h28;

    // Position of the frame decoder within a transaction.
    typedef enum logic [3:0] {
        PH_HDR,
        PH_ADR1,
        PH_ADR2,
        PH_DUMMY,
        PH_RDATA,
        PH_WDATA,
        PH_CTAIL1,
        PH_CTAIL2,
        PH_SKIP
    } phase_t;

    // True for a code that the controller understands; others are reserved.
    function automatic logic cmd_is_listed(input logic [5:0] code);
        unique case (code)
            CMD_WAKE, CMD_STANDBY, CMD_NAP, CMD_SRC_XTAL, CMD_SRC_RC,
            CMD_OFF, CMD_PLL_LOW, CMD_PLL_HIGH, CMD_CORE_RST: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Brings SCLK, MOSI and CS_N into the system clock domain and flags
// serial clock edges. Assumes STAGES >= 2 and a serial clock half period
// of at least STAGES system clocks. Edges are only flagged while selected.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic mosi_pin,
    input  logic cs_n_pin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic cs_active
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sclk_sr;
    logic [TOP:0] mosi_sr;
    logic [TOP:0] cs_sr;
    logic         sclk_last;

    // Synchronizer chains plus one extra flop on SCLK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sr   <= '0;
            mosi_sr   <= '0;
            cs_sr     <= '1;
            sclk_last <= 1'b0;
        end else begin
            sclk_sr   <= {sclk_sr[TOP-1:0], sclk_pin};
            mosi_sr   <= {mosi_sr[TOP-1:0], mosi_pin};
            cs_sr     <= {cs_sr[TOP-1:0], cs_n_pin};
            sclk_last <= sclk_sr[TOP];
        end
    end

    assign cs_active = ~cs_sr[TOP];
    assign mosi_s    = mosi_sr[TOP];
    assign sclk_rise = cs_active &  sclk_sr[TOP] & ~sclk_last;
    assign sclk_fall = cs_active & ~sclk_sr[TOP] &  sclk_last;

endmodule

// File: rtl/spi_byte_shifter.sv
// Bit-level shifting: assembles MOSI bytes on rising edges and shifts the
// transmit byte out on falling edges. The falling edge that closes a byte
// does not shift, so a byte loaded at a boundary shows its MSB first.
// All state clears while chip select is inactive.
module spi_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso_bit
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    // Receive path: shift in on rising edges and flag a completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= sclk_rise && (bit_cnt == LAST_BIT);
            if (sclk_rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Transmit path: load at a byte boundary, else shift on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            tx_sh <= '0;
        end else if (tx_load) begin
            tx_sh <= tx_byte;
        end else if (sclk_fall && (bit_cnt != '0)) begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign rx_byte  = rx_sh;
    assign miso_bit = tx_sh[BYTE_W-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
// Byte-level frame decoder. Reads the prefix, gathers the address, runs
// read and write bursts with auto-increment and validates command frames.
// Assumes bus read data arrives one clock after bus_re and that the upper
// address field (ADDR_W-16 bits) fits in the 6 bits after the prefix.
module spi_frame_ctrl
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic              low_power,
    input  logic [7:0]        bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output logic              cmd_valid,
    output logic [5:0]        cmd_code
);
    localparam int HI_W = ADDR_W - 16;

    phase_t            phase;
    logic              is_read;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        hold;
    logic              re_q;
    logic [5:0]        code_q;
    logic              tail_bad;
    logic [ADDR_W-1:0] addr_full;

    // Address as it stands once the low byte now arriving is included.
    assign addr_full = {addr[ADDR_W-1:8], rx_byte};

    // Frame sequencing, address counter, bus strobes and command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_HDR;
            is_read   <= 1'b0;
            addr      <= '0;
            hold      <= '0;
            re_q      <= 1'b0;
            code_q    <= '0;
            tail_bad  <= 1'b0;
            bus_wdata <= '0;
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
        end else begin
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
            cmd_valid <= 1'b0;
            re_q      <= bus_re;
            if (re_q) begin
                hold <= bus_rdata;
            end
            if (bus_we) begin
                addr <= addr + 1'b1;
            end
            if (!cs_active) begin
                phase    <= PH_HDR;
                tail_bad <= 1'b0;
            end else if (byte_done) begin
                unique case (phase)
                    PH_HDR: begin
                        unique case (rx_byte[7:6])
                            PFX_READ, PFX_WRITE: begin
                                addr[ADDR_W-1:16] <= rx_byte[HI_W-1:0];
                                is_read <= (rx_byte[7:6] == PFX_READ);
                                phase   <= PH_ADR1;
                            end
                            PFX_CMD: begin
                                code_q <= rx_byte[5:0];
                                phase  <= PH_CTAIL1;
                            end
                            PFX_UNDEF: phase <= PH_SKIP;
                        endcase
                    end
                    PH_ADR1: begin
                        addr[15:8] <= rx_byte;
                        phase      <= PH_ADR2;
                    end
                    PH_ADR2: begin
                        addr[7:0] <= rx_byte;
                        if (is_read) begin
                            bus_re <= 1'b1;
                            phase  <= PH_DUMMY;
                            if (low_power && (addr_full == '0)) begin
                                cmd_valid <= 1'b1;
                                cmd_code  <= CMD_WAKE;
                            end
                        end else begin
                            phase <= PH_WDATA;
                        end
                    end
                    PH_DUMMY, PH_RDATA: begin
                        addr   <= addr + 1'b1;
                        bus_re <= 1'b1;
                        phase  <= PH_RDATA;
                    end
                    PH_WDATA: begin
                        bus_we    <= 1'b1;
                        bus_wdata <= rx_byte;
                    end
                    PH_CTAIL1: begin
                        tail_bad <= (rx_byte != 8'h00);
                        phase    <= PH_CTAIL2;
                    end
                    PH_CTAIL2: begin
                        if ((rx_byte == 8'h00) && !tail_bad && cmd_is_listed(code_q)) begin
                            cmd_valid <= 1'b1;
                            cmd_code  <= code_q;
                        end
                        phase <= PH_SKIP;
                    end
                    default: phase <= PH_SKIP;
                endcase
            end
        end
    end

    assign bus_addr = addr;
    assign tx_load  = byte_done && cs_active && ((phase == PH_DUMMY) || (phase == PH_RDATA));
    assign tx_byte  = hold;

endmodule

// File: rtl/spi_host_slave.sv
// Top level of the serial host slave: pin synchronizers, byte shifter and
// frame decoder. Assumes the serial clock half period is at least four
// system clocks. MISO is driven only while chip select is seen active.
module spi_host_slave #(
    parameter int ADDR_W      = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              low_power,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [7:0]        bus_rdata,
    output logic              cmd_valid,
    output logic [5:0]        cmd_code
);
    logic       sclk_rise;
    logic       sclk_fall;
    logic       mosi_s;
    logic       cs_active;
    logic       byte_done;
    logic [7:0] rx_byte;
    logic       miso_bit;
    logic       tx_load;
    logic [7:0] tx_byte;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_pin  (spi_sclk),
        .mosi_pin  (spi_mosi),
        .cs_n_pin  (spi_cs_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .cs_active (cs_active)
    );

    spi_byte_shifter #(.BYTE_W(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso_bit  (miso_bit)
    );

    spi_frame_ctrl #(.ADDR_W(ADDR_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .low_power (low_power),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code)
    );

    assign spi_miso_oe = cs_active;
    assign spi_miso    = cs_active & miso_bit;

endmodule

// File: rtl/spi_host_slave_chk.sv
// Port-level checker for the serial host slave, attached by bind.
// Tracks the previous strobe address within a transaction to check steps.
module spi_host_slave_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic              low_power,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [7:0]        bus_rdata,
    input logic              cmd_valid,
    input logic [5:0]        cmd_code
);
    logic              we_seen;
    logic              re_seen;
    logic [ADDR_W-1:0] we_prev;
    logic [ADDR_W-1:0] re_prev;

    // Remember the last strobe address of the current transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || spi_cs_n) begin
            we_seen <= 1'b0;
            re_seen <= 1'b0;
            we_prev <= '0;
            re_prev <= '0;
        end else begin
            if (bus_we) begin
                we_seen <= 1'b1;
                we_prev <= bus_addr;
            end
            if (bus_re) begin
                re_seen <= 1'b1;
                re_prev <= bus_addr;
            end
        end
    end

    a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
        |-> (!spi_miso_oe && !bus_we && !bus_re && !cmd_valid));

    a_r1_miso_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);

    a_r2_write_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && we_seen && !spi_cs_n) |-> (bus_addr == ADDR_W'(we_prev + 1'b1)));

    a_r4_read_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && re_seen && !spi_cs_n) |-> (bus_addr == ADDR_W'(re_prev + 1'b1)));

    a_r4_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    a_r6_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

endmodule

bind spi_host_slave spi_host_slave_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/spi_host_slave_tb.sv
// Bench: a 256-byte memory model on the bus, a bit-banged host, a vector
// table of write/read bursts, then directed tests for commands and corners.
module spi_host_slave_tb;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic        low_power = 1'b0;
    logic [21:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [7:0]  bus_rdata;
    logic        cmd_valid;
    logic [5:0]  cmd_code;

    always #5 clk = ~clk;

    spi_host_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .low_power(low_power), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    // Memory model and strobe logs.
    logic [7:0]  mem [256];
    logic [7:0]  shadow [256];
    logic [21:0] wlog_addr [64];
    logic [7:0]  wlog_data [64];
    int          wcnt = 0;
    int          rcnt = 0;
    int          ccnt = 0;
    logic [5:0]  clast = '0;
    int          vectors = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'(i) ^ 8'hA5;
            shadow[i] = 8'(i) ^ 8'hA5;
        end
        bus_rdata = '0;
    end

    always @(posedge clk) begin
        if (bus_we) begin
            mem[bus_addr[7:0]]  <= bus_wdata;
            wlog_addr[wcnt % 64] <= bus_addr;
            wlog_data[wcnt % 64] <= bus_wdata;
            wcnt <= wcnt + 1;
        end
        if (bus_re) begin
            bus_rdata <= mem[bus_addr[7:0]];
            rcnt <= rcnt + 1;
        end
        if (cmd_valid) begin
            ccnt  <= ccnt + 1;
            clast <= cmd_code;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sbyte(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = o[b];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            i[b] = spi_miso;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic sel;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel;
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic hdr(input logic [1:0] pfx, input logic [21:0] a);
        logic [7:0] d;
        sbyte({pfx, a[21:16]}, d);
        sbyte(a[15:8], d);
        sbyte(a[7:0], d);
    endtask

    task automatic cmd3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] d;
        sel();
        sbyte(b0, d);
        sbyte(b1, d);
        sbyte(b2, d);
        desel();
    endtask

    function automatic logic [7:0] wd(input logic [21:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    // Vector table: {is_read, start address, burst length}.
    localparam int NVEC = 6;
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 22'h000010, 4'd4},
        {1'b1, 22'h000010, 4'd4},
        {1'b1, 22'h000080, 4'd3},
        {1'b0, 22'h3FFFFE, 4'd4},
        {1'b1, 22'h3FFFFE, 4'd4},
        {1'b1, 22'h012345, 4'd1}
    };

    initial begin
        logic [7:0]  d;
        logic [21:0] a;
        int          n;
        int          w0;
        int          r0;
        int          c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state.
        check("R1 miso_oe after reset", 32'(spi_miso_oe), 0);
        check("R1 miso after reset", 32'(spi_miso), 0);
        check("R1 no strobes after reset", 32'(wcnt + rcnt + ccnt), 0);

        // R2 R3 R5: table of bursts.
        for (int v = 0; v < NVEC; v++) begin
            a = VEC[v][25:4];
            n = int'(VEC[v][3:0]);
            w0 = wcnt;
            sel();
            if (VEC[v][26]) begin
                hdr(2'b00, a);
                sbyte(8'h00, d);
                for (int k = 0; k < n; k++) begin
                    logic [21:0] ak;
                    ak = a + 22'(k);
                    sbyte(8'hFF, d);
                    check("R3 R5 read data", 32'(d), 32'(shadow[ak[7:0]]));
                end
                desel();
            end else begin
                hdr(2'b10, a);
                for (int k = 0; k < n; k++) begin
                    logic [21:0] ak;
                    ak = a + 22'(k);
                    sbyte(wd(ak), d);
                    shadow[ak[7:0]] = wd(ak);
                end
                desel();
                check("R2 write count", 32'(wcnt - w0), 32'(n));
                for (int k = 0; k < n; k++) begin
                    logic [21:0] ak;
                    ak = a + 22'(k);
                    check("R2 R5 write addr", 32'(wlog_addr[(w0 + k) % 64]), 32'(ak));
                    check("R2 write data", 32'(wlog_data[(w0 + k) % 64]), 32'(wd(ak)));
                end
            end
        end

        // R4: address plus dummy only gives two read requests.
        r0 = rcnt;
        sel(); hdr(2'b00, 22'h000040); sbyte(8'h00, d); desel();
        check("R4 read requests for header and dummy", 32'(rcnt - r0), 2);

        // R9: wake on read of address 0 in low power.
        low_power = 1'b1;
        c0 = ccnt;
        sel(); hdr(2'b00, 22'h000000); sbyte(8'h00, d); desel();
        check("R9 wake pulse count", 32'(ccnt - c0), 1);
        check("R9 wake code", 32'(clast), 0);
        c0 = ccnt;
        sel(); hdr(2'b00, 22'h000004); sbyte(8'h00, d); desel();
        check("R9 no wake for nonzero address", 32'(ccnt - c0), 0);
        low_power = 1'b0;
        sel(); hdr(2'b00, 22'h000000); sbyte(8'h00, d); desel();
        check("R9 no wake when active", 32'(ccnt - c0), 0);

        // R6: listed commands.
        c0 = ccnt;
        cmd3(8'h42, 8'h00, 8'h00);
        check("R6 cmd count", 32'(ccnt - c0), 1);
        check("R6 cmd code 02", 32'(clast), 32'h02);
        cmd3(8'h62, 8'h00, 8'h00);
        check("R6 cmd code 22", 32'(clast), 32'h22);

        // R7: reserved code and bad tails.
        c0 = ccnt;
        cmd3(8'h43, 8'h00, 8'h00);
        cmd3(8'h41, 8'h01, 8'h00);
        cmd3(8'h41, 8'h00, 8'h80);
        check("R7 ignored commands", 32'(ccnt - c0), 0);

        // R8: undefined prefix.
        w0 = wcnt; r0 = rcnt; c0 = ccnt;
        sel();
        sbyte(8'hC0, d); sbyte(8'h00, d); sbyte(8'h00, d); sbyte(8'h00, d);
        sbyte(8'h55, d);
        desel();
        check("R8 no bus or cmd", 32'((wcnt - w0) + (rcnt - r0) + (ccnt - c0)), 0);
        check("R8 miso stays 0", 32'(d), 0);

        // R10: abort mid-byte, then a clean write.
        sel();
        for (int b = 0; b < 3; b++) begin
            spi_mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        desel();
        w0 = wcnt;
        sel(); hdr(2'b10, 22'h000020); sbyte(8'h77, d); desel();
        check("R10 write count after abort", 32'(wcnt - w0), 1);
        check("R10 write addr after abort", 32'(wlog_addr[w0 % 64]), 32'h20);
        check("R10 write data after abort", 32'(wlog_data[w0 % 64]), 32'h77);

        // R1: idle again after all traffic.
        check("R1 miso_oe idle", 32'(spi_miso_oe), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule